// File: doc/BRIEF.md
# Four-Channel PWM Timer with Paired Prescalers

This block generates four pulse-width-modulated outputs from a single clock. Software configures it through a 32-bit word-wide register port: a shared prescaler word, a clock-selector word, a control word, and per-channel reload, compare and read-only data words. Channel 0 and channel 1 take their tick from one 8-bit prescaler. Channel 2 and channel 3 take theirs from a second one. Each channel then divides that tick by a power of two of its own choosing, or passes it straight through.

Each channel runs a 16-bit down-counter. It loads the reload value and counts one step per channel tick, so a period lasts reload+1 ticks. The output is in its active phase while the count is at or below the compare value. This gives compare+1 active ticks per period, and the output stays active for the whole period when compare is at or above reload. A per-channel inverter flips the polarity. Reload and compare writes are shadowed and are only adopted at a period boundary, so a mid-period update cannot produce a runt pulse. The interrupt-enable and interrupt-status words are plain storage, and the four interrupt lines stay deasserted.

Top module: `pwm4_timer`

## Requirements
- R1: Reset clears every register to zero. A read returns the stored value one cycle after the read strobe. Only the defined fields are stored: the prescaler word keeps bits [15:0], the selector word keeps bits [2:0], [6:4], [10:8] and [14:12], and the control word keeps bits [3:0], [11:8], [15:12] and [19:16].
- R2: A reload or compare write whose value exceeds 65535 stores 65535. Smaller values are stored unchanged.
- R3: The per-channel data words (channel n at 0x14+12n) and the four words at 0x44 to 0x50 read zero and ignore writes. Unmapped or misaligned addresses also read zero.
- R4: Channels 0 and 1 use prescaler bits [7:0], and channels 2 and 3 use bits [15:8]. A field value p divides the clock by p+1. The period in clock cycles is (reload+1)·(p+1)·div.
- R5: Channel n's 3-bit selector at bit 4n gives div = 2, 4, 8 or 16 for codes 0 to 3, and div = 1 for codes 4 to 7.
- R6: The output is high for min(compare+1, reload+1) ticks per period. When compare is at or above reload, it is high for the whole period.
- R7: Control bit 2 of a channel inverts its output, so the high time becomes the period minus the R6 high time.
- R8: A channel runs only when control bit 0 (enable) and bit 3 (continuous mode) are both set. Control nibbles sit at bit offsets 0, 8, 12 and 16. A channel that is not running holds its output at the level of its inverter bit.
- R9: A new reload or compare value takes effect only when the counter wraps at the end of the current period.
- R10: The interrupt-enable word (0x3C) and the status word (0x40) store and return all 32 bits. The four interrupt lines stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one full word |
| bus_rd | input | 1 | Read strobe; data is returned next cycle |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | PWM waveforms, one bit per channel |
| irq_out | output | 4 | Interrupt lines, one per channel |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 16-bit counters and 8-bit prescaler fields. It sweeps small reload and compare values, prescaler settings 0, 1 and 2, and all eight selector codes (staggered across the channels), so every period stays under 200 cycles. It counts high cycles and rising edges over a window of exactly one period. Because the waveform is periodic, the expected counts do not depend on phase, and the bench derives them from the period arithmetic. Directed cases cover saturation, the read-only and unmapped words, idle levels, and a compare change made in the middle of a period.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int NUM_CH     = 4;
    localparam int CH_PER_PRE = 2;
    localparam int NUM_PRE    = NUM_CH / CH_PER_PRE;
    localparam int PRE_W      = 8;
    localparam int SEL_W      = 3;
    localparam int CTL_W      = 4;
    localparam int CNT_W      = 16;
    localparam int DIV_W      = 4;
    localparam int DIV_CODES  = 4;
    localparam int DATA_W     = 32;
    localparam int IDX_W      = $clog2(NUM_CH);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // control nibble bit positions
    localparam int EN_BIT  = 0;
    localparam int INV_BIT = 2;
    localparam int TOG_BIT = 3;

    // byte offsets
    localparam int OFF_PRE    = 'h00;
    localparam int OFF_SEL    = 'h04;
    localparam int OFF_CTL    = 'h08;
    localparam int OFF_GRP    = 'h0C;
    localparam int GRP_STRIDE = 12;
    localparam int OFF_IEN    = 'h3C;
    localparam int OFF_IST    = 'h40;
    localparam int OFF_WD     = 'h44;

    typedef struct packed {
        logic             en;
        logic             inv;
        logic             toggle;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cmp;
    } chan_cfg_t;

    typedef enum logic [3:0] {
        RK_NONE, RK_PRE, RK_SEL, RK_CTL, RK_RELOAD,
        RK_CMP, RK_DATA, RK_IEN, RK_IST, RK_WDOG
    } reg_kind_e;

    function automatic int ctl_pos(input int ch);
        return (ch == 0) ? 0 : (4 * ch + 4);
    endfunction

    function automatic int sel_pos(input int ch);
        return 4 * ch;
    endfunction

    function automatic logic [DATA_W-1:0] pre_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_PRE * PRE_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] sel_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++)
            for (int b = 0; b < SEL_W; b++) m[sel_pos(c) + b] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++)
            for (int b = 0; b < CTL_W; b++) m[ctl_pos(c) + b] = 1'b1;
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] saturate(input logic [DATA_W-1:0] w);
        return (w > DATA_W'(CNT_MAX)) ? CNT_MAX : w[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output chan_cfg_t [NUM_CH-1:0]         cfg,
    output logic [NUM_PRE-1:0][PRE_W-1:0]  pre_val
);

    logic [DATA_W-1:0] pre_q, sel_q, ctl_q, ien_q, ist_q, rdata_q;
    logic [NUM_CH-1:0][CNT_W-1:0] reload_q, cmp_q;

    reg_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] a32;
    logic [DATA_W-1:0] rd_val;

    // address decode
    always_comb begin
        kind = RK_NONE;
        idx  = '0;
        a32  = DATA_W'(addr);
        if (a32[1:0] == 2'b00) begin
            if (a32 == DATA_W'(OFF_PRE)) kind = RK_PRE;
            if (a32 == DATA_W'(OFF_SEL)) kind = RK_SEL;
            if (a32 == DATA_W'(OFF_CTL)) kind = RK_CTL;
            if (a32 == DATA_W'(OFF_IEN)) kind = RK_IEN;
            if (a32 == DATA_W'(OFF_IST)) kind = RK_IST;
            if (a32 >= DATA_W'(OFF_WD) && a32 <= DATA_W'(OFF_WD + 4 * (NUM_CH - 1)))
                kind = RK_WDOG;
            for (int c = 0; c < NUM_CH; c++) begin
                if (a32 == DATA_W'(OFF_GRP + GRP_STRIDE * c)) begin
                    kind = RK_RELOAD;
                    idx  = IDX_W'(c);
                end
                if (a32 == DATA_W'(OFF_GRP + GRP_STRIDE * c + 4)) begin
                    kind = RK_CMP;
                    idx  = IDX_W'(c);
                end
                if (a32 == DATA_W'(OFF_GRP + GRP_STRIDE * c + 8)) begin
                    kind = RK_DATA;
                    idx  = IDX_W'(c);
                end
            end
        end
    end

    // write side
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q    <= '0;
            sel_q    <= '0;
            ctl_q    <= '0;
            ien_q    <= '0;
            ist_q    <= '0;
            reload_q <= '0;
            cmp_q    <= '0;
        end else if (wr_en) begin
            case (kind)
                RK_PRE:    pre_q <= wdata & pre_mask();
                RK_SEL:    sel_q <= wdata & sel_mask();
                RK_CTL:    ctl_q <= wdata & ctl_mask();
                RK_IEN:    ien_q <= wdata;
                RK_IST:    ist_q <= wdata;
                RK_RELOAD: reload_q[idx] <= saturate(wdata);
                RK_CMP:    cmp_q[idx]    <= saturate(wdata);
                default:   ;
            endcase
        end
    end

    // read side
    always_comb begin
        case (kind)
            RK_PRE:    rd_val = pre_q;
            RK_SEL:    rd_val = sel_q;
            RK_CTL:    rd_val = ctl_q;
            RK_IEN:    rd_val = ien_q;
            RK_IST:    rd_val = ist_q;
            RK_RELOAD: rd_val = DATA_W'(reload_q[idx]);
            RK_CMP:    rd_val = DATA_W'(cmp_q[idx]);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign rdata = rdata_q;

    // per-channel configuration fan-out
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
        localparam int CP = ctl_pos(c);
        localparam int SP = sel_pos(c);
        assign cfg[c].en     = ctl_q[CP + EN_BIT];
        assign cfg[c].inv    = ctl_q[CP + INV_BIT];
        assign cfg[c].toggle = ctl_q[CP + TOG_BIT];
        assign cfg[c].sel    = sel_q[SP +: SEL_W];
        assign cfg[c].reload = reload_q[c];
        assign cfg[c].cmp    = cmp_q[c];
    end

    for (genvar p = 0; p < NUM_PRE; p++) begin : g_pre
        assign pre_val[p] = pre_q[p * PRE_W +: PRE_W];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pre_q == '0 && ctl_q == '0 && sel_q == '0 && rdata == '0));

    // R2
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == RK_RELOAD && wdata > DATA_W'(CNT_MAX))
        |=> reload_q[$past(idx)] == CNT_MAX);

endmodule

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler
    import pwm4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] div_val,
    output logic             tick
);

    logic [PRE_W-1:0] cnt_q;

    assign tick = (cnt_q >= div_val);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div_val != '0) |=> (!tick || div_val == '0));

endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
    import pwm4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      pre_tick,
    output logic      pwm_o
);

    logic             running;
    logic             bypass;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_mask;
    logic             ch_tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_cmp_q;
    logic             wrap;
    logic             active;

    assign running  = cfg.en & cfg.toggle;
    assign bypass   = (cfg.sel >= SEL_W'(DIV_CODES));
    assign div_mask = ~({DIV_W{1'b1}} << (3'(cfg.sel[1:0]) + 3'd1));
    assign ch_tick  = pre_tick & (bypass | ((div_q & div_mask) == div_mask));
    assign wrap     = ch_tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            cnt_q     <= '0;
            act_cmp_q <= '0;
        end else if (!running) begin
            div_q     <= '0;
            cnt_q     <= cfg.reload;
            act_cmp_q <= cfg.cmp;
        end else begin
            if (pre_tick) div_q <= div_q + 1'b1;
            if (wrap) begin
                cnt_q     <= cfg.reload;
                act_cmp_q <= cfg.cmp;
            end else if (ch_tick) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign active = (cnt_q <= act_cmp_q);
    assign pwm_o  = running ? (active ^ cfg.inv) : cfg.inv;

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en || !cfg.toggle) |-> (pwm_o == cfg.inv));

    // R9
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !wrap) |=> $stable(act_cmp_q));

    // R9
    reload_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (running && wrap) |=> cnt_q == $past(cfg.reload));

    // R6
    full_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (running && cnt_q <= act_cmp_q) |-> (pwm_o == !cfg.inv));

endmodule

// File: rtl/pwm4_timer.sv
module pwm4_timer
    import pwm4_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [3:0]        pwm_out,
    output logic [3:0]        irq_out
);

    chan_cfg_t [NUM_CH-1:0]        cfg;
    logic [NUM_PRE-1:0][PRE_W-1:0] pre_val;
    logic [NUM_PRE-1:0]            pre_tick;

    pwm4_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .rd_en   (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .cfg     (cfg),
        .pre_val (pre_val)
    );

    for (genvar p = 0; p < NUM_PRE; p++) begin : g_pre
        pwm4_prescaler u_pre (
            .clk     (clk),
            .rst     (rst),
            .div_val (pre_val[p]),
            .tick    (pre_tick[p])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm4_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg[c]),
            .pre_tick (pre_tick[c / CH_PER_PRE]),
            .pwm_o    (pwm_out[c])
        );
    end

    assign irq_out = '0;

endmodule

// File: tb/pwm4_timer_test.sv
`timescale 1ns/1ps
module pwm4_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    logic [3:0]  irq_out;

    int n_chk = 0;
    int n_bad = 0;
    int hi_cnt[4];
    int rise_cnt[4];

    always #2.5 clk = ~clk;

    pwm4_timer #(.ADDR_W(12)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic int divf(input int code);
        return (code < 4) ? (2 << code) : 1;
    endfunction

    function automatic int ctlp(input int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    task automatic measure(input int pair, input int len);
        logic [3:0] prev;
        for (int c = 0; c < 4; c++) begin hi_cnt[c] = 0; rise_cnt[c] = 0; end
        prev = pwm_out;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            for (int c = 2 * pair; c < 2 * pair + 2; c++) begin
                if (pwm_out[c]) hi_cnt[c]++;
                if (pwm_out[c] && !prev[c]) rise_cnt[c]++;
            end
            prev = pwm_out;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        for (int a = 0; a <= 'h50; a += 4) begin
            rd(12'(a), d);
            check("R1 reset readback", d, 32'h0);
        end
        check("R8 reset outputs", 32'(pwm_out), 32'h0);
        check("R10 reset irq", 32'(irq_out), 32'h0);

        // R1: field masks
        wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, d); check("R1 prescaler mask", d, 32'h0000_FFFF);
        wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, d); check("R1 selector mask", d, 32'h0000_7777);
        wr(12'h008, 32'hFFFF_FFFF); rd(12'h008, d); check("R1 control mask", d, 32'h000F_FF0F);
        wr(12'h008, 32'h0);

        // R2: saturation
        wr(12'h024, 32'h0001_2345); rd(12'h024, d); check("R2 reload2 sat", d, 32'h0000_FFFF);
        wr(12'h01C, 32'h0001_0000); rd(12'h01C, d); check("R2 cmp1 sat", d, 32'h0000_FFFF);
        wr(12'h00C, 32'h0000_FFFF); rd(12'h00C, d); check("R2 reload0 max", d, 32'h0000_FFFF);
        wr(12'h034, 32'h0000_1234); rd(12'h034, d); check("R2 cmp3 plain", d, 32'h0000_1234);

        // R3: read-only, watchdog, unmapped, misaligned
        wr(12'h020, 32'hDEAD_BEEF); rd(12'h020, d); check("R3 data1 ignored", d, 32'h0);
        wr(12'h048, 32'hDEAD_BEEF); rd(12'h048, d); check("R3 wdog ignored", d, 32'h0);
        rd(12'h100, d); check("R3 unmapped", d, 32'h0);
        rd(12'h00D, d); check("R3 misaligned", d, 32'h0);
        rd(12'h00C, d); check("R3 neighbour intact", d, 32'h0000_FFFF);

        // R10: interrupt storage
        wr(12'h03C, 32'hA5A5_0003); rd(12'h03C, d); check("R10 enable store", d, 32'hA5A5_0003);
        wr(12'h040, 32'h0000_000F); rd(12'h040, d); check("R10 status store", d, 32'h0000_000F);
        check("R10 irq low", 32'(irq_out), 32'h0);

        // R8: idle levels
        wr(12'h000, 32'h0);
        wr(12'h004, 32'h4444);
        for (int c = 0; c < 4; c++) begin
            wr(12'(12 + 12 * c), 32'd3);
            wr(12'(16 + 12 * c), 32'd1);
        end
        // ch0 en+inv one-shot, ch1 off, ch2 inv only, ch3 continuous without enable
        wr(12'h008, 32'h5 | (32'h0 << 8) | (32'h4 << 12) | (32'h8 << 16));
        begin
            int bad_cyc = 0;
            for (int k = 0; k < 64; k++) begin
                @(negedge clk);
                if (pwm_out !== 4'b0101) bad_cyc++;
            end
            check("R8 idle level cycles off", 32'(bad_cyc), 32'h0);
        end
        check("R8 idle level value", 32'(pwm_out), 32'h5);

        // R9: compare change mid-period
        wr(12'h008, 32'h0);
        wr(12'h00C, 32'd99);
        wr(12'h010, 32'd49);
        wr(12'h008, 32'h9);
        begin
            logic prev;
            int run, guard;
            prev = pwm_out[0]; guard = 0;
            while (!(pwm_out[0] && !prev) && guard < 400) begin
                prev = pwm_out[0]; @(negedge clk); guard++;
            end
            run = 1;
            bus_addr = 12'h010; bus_wdata = 32'd9; bus_wr = 1'b1;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                bus_wr = 1'b0;
                if (pwm_out[0]) run++; else break;
            end
            check("R9 old compare kept to period end", 32'(run), 32'd50);
            prev = pwm_out[0]; guard = 0;
            while (!(pwm_out[0] && !prev) && guard < 400) begin
                prev = pwm_out[0]; @(negedge clk); guard++;
            end
            run = 1;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (pwm_out[0]) run++; else break;
            end
            check("R9 new compare next period", 32'(run), 32'd10);
        end

        // R4 R5 R6 R7: sweep
        for (int pi = 0; pi < 2; pi++) begin
            for (int code = 0; code < 8; code++) begin
                for (int ri = 0; ri < 2; ri++) begin
                    for (int ci = 0; ci < 3; ci++) begin
                        int pa, pb, rl, cm, pmax;
                        int per[4];
                        int exp_hi, act_t, pv;
                        logic [31:0] csr_w;
                        pa = pi * 2; pb = (pa == 0) ? 1 : 0;
                        rl = (ri == 0) ? 1 : 3;
                        cm = ci * 2;
                        wr(12'h008, 32'h0);
                        wr(12'h000, 32'(pa) | (32'(pb) << 8));
                        csr_w = '0;
                        for (int c = 0; c < 4; c++)
                            csr_w |= 32'((code + c) % 8) << (4 * c);
                        wr(12'h004, csr_w);
                        for (int c = 0; c < 4; c++) begin
                            wr(12'(12 + 12 * c), 32'(rl));
                            wr(12'(16 + 12 * c), 32'(cm));
                        end
                        wr(12'h008, (32'h9 << ctlp(0)) | (32'hD << ctlp(1)) |
                                    (32'hD << ctlp(2)) | (32'h9 << ctlp(3)));
                        pmax = 0;
                        for (int c = 0; c < 4; c++) begin
                            pv = (c < 2) ? pa : pb;
                            per[c] = (rl + 1) * divf((code + c) % 8) * (pv + 1);
                            if (per[c] > pmax) pmax = per[c];
                        end
                        repeat (2 * pmax + 4) @(negedge clk);
                        for (int pair = 0; pair < 2; pair++) begin
                            measure(pair, per[2 * pair]);
                            for (int c = 2 * pair; c < 2 * pair + 2; c++) begin
                                if (per[c] != per[2 * pair]) begin
                                    // odd channel of pair differs in divider: measure separately
                                    measure(pair, per[c]);
                                end
                                pv = (c < 2) ? pa : pb;
                                act_t = (((cm < rl) ? cm : rl) + 1) * divf((code + c) % 8) * (pv + 1);
                                exp_hi = (c == 1 || c == 2) ? per[c] - act_t : act_t;
                                check((c == 1 || c == 2) ? "R7 R4 R5 R6 inverted high time" :
                                      "R4 R5 R6 high time", 32'(hi_cnt[c]), 32'(exp_hi));
                                check("R4 R5 rising edges per period", 32'(rise_cnt[c]),
                                      (exp_hi > 0 && exp_hi < per[c]) ? 32'd1 : 32'd0);
                            end
                        end
                        check("R10 irq stays low", 32'(irq_out), 32'h0);
                    end
                end
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule